// File: doc/BRIEF.md
# Prioritized Reference Clock Selector

This block picks one active timing reference from a set of candidate clock inputs. The block does not measure the clocks. Each candidate arrives with a qualification flag from upstream monitors and a programmable 4-bit priority. The block ranks the qualified candidates by priority and keeps a registered selection.

Two switching policies are supported. In revertive operation the selection always follows the best candidate. In non-revertive operation the block keeps the current reference while that reference stays qualified, and it chooses again only after the reference is lost.

Alongside the selection, the block reports the three best qualified candidates. It also raises a sticky loss flag, with a maskable interrupt, when the last qualified candidate goes away.

Top module: `ref_clk_selector`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sel_idx`, `rank1`, `rank2`, `rank3` and `all_lost` become 0, and they stay 0 until new inputs are registered after reset is released.
- R2: Input bit i of `in_valid` has its priority in `in_prio[4*i+3:4*i]`. The input is qualified only when its valid bit is 1 and its priority is nonzero. Priority 0 disables the input. Among nonzero priorities, a smaller value ranks higher.
- R3: `rank1`, `rank2` and `rank3` give the best, second and third qualified inputs as 1-based indices (input bit i is reported as i+1). A rank slot with no qualified input to fill it reads 0.
- R4: Qualified inputs with equal priority are ordered by index, with the smaller index first. This holds for both the ranking and the selection.
- R5: When `revertive` is 1, the next registered `sel_idx` equals the next registered `rank1`.
- R6: When `revertive` is 0 and the currently selected input is still qualified, `sel_idx` keeps its value, even if a higher-priority input becomes qualified.
- R7: When `revertive` is 0 and the selected input is no longer qualified (or nothing is selected), `sel_idx` takes the index of the best qualified input.
- R8: `sel_idx` reads 0 whenever no input is qualified.
- R9: `all_lost` is set on the clock edge at which the set of qualified inputs changes from non-empty to empty. It then holds until a cycle with `lost_clr` = 1 clears it. If a set and a clear happen in the same cycle, the set wins. An input set that stays empty does not set the flag again.
- R10: `irq` is 1 exactly when `all_lost` is 1 and `irq_en` is 1.
- R11: A change on `in_valid` or `in_prio` shows on `sel_idx` and on the rank outputs at the first rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 14 | Qualification flag per candidate, bit i = input i+1 |
| in_prio | input | 56 | 4-bit priority per candidate, bits [4i+3:4i]; 0 = disabled |
| revertive | input | 1 | 1 = revertive switching, 0 = non-revertive |
| irq_en | input | 1 | Interrupt enable for the loss flag |
| lost_clr | input | 1 | Write-one-to-clear pulse for `all_lost` |
| sel_idx | output | 4 | Selected input, 1-based, 0 = none |
| rank1 | output | 4 | Best qualified input, 0 = none |
| rank2 | output | 4 | Second qualified input, 0 = none |
| rank3 | output | 4 | Third qualified input, 0 = none |
| all_lost | output | 1 | Sticky flag: every candidate became unqualified |
| irq | output | 1 | Interrupt, `all_lost` gated by `irq_en` |

## Verification
The ranking is exercised with several patterns: distinct priorities given in scrambled order, full four-way ties, an input that is valid but has priority 0, and candidates at the top two indices. Together these separate a correct priority compare from one that uses index order, reversed order or a tie-break toward the larger index. A non-revertive sequence first brings in a better input, which must not cause a switch. It then removes the active input, which must cause a switch, and a revertive step then shows the switch to the tie winner. Directed steps check the loss flag: set on the transition to empty, clear on the clear pulse, set winning over a simultaneous clear, no new set while the input set stays empty, interrupt masking, and the one-edge latency.

// File: rtl/ref_sel_pkg.sv
// Package: shared definitions for the reference clock selector.
// Assumes: one-based input numbering with 0 meaning "no input".
package ref_sel_pkg;
    // Number of ranking slots reported alongside the selection.
    localparam int unsigned RANK_SLOTS = 3;

    // Switching policy encoded on the revertive pin.
    typedef enum logic {
        SW_HOLD   = 1'b0,
        SW_FOLLOW = 1'b1
    } sw_policy_e;

    // Converts a zero-based input position to a one-based reported index.
    function automatic int unsigned to_index(input int unsigned pos);
        return pos + 1;
    endfunction
endpackage

// File: rtl/ref_rank_core.sv
// Module: ref_rank_core
// Purpose: combinational ranking of qualified candidates by priority.
// Assumes: priority 0 disables an input; a smaller nonzero value is better;
//          equal priorities are ordered by ascending position. Picks are
//          one-based, with 0 for an empty slot.
module ref_rank_core #(
    parameter int N_IN  = 14,
    parameter int PRI_W = 4,
    parameter int SLOTS = 3,
    parameter int IDX_W = $clog2(N_IN + 1)
) (
    input  logic [N_IN-1:0]        valid,
    input  logic [N_IN*PRI_W-1:0]  prio,
    output logic [N_IN-1:0]        qual,
    output logic [SLOTS*IDX_W-1:0] picks,
    output logic                   any_qual
);
    import ref_sel_pkg::*;

    logic [PRI_W-1:0] prio_a [N_IN];

    // Slice the priority field of each input and work out its qualification.
    for (genvar g = 0; g < N_IN; g++) begin : g_qual
        assign prio_a[g] = prio[g*PRI_W +: PRI_W];
        assign qual[g]   = valid[g] && (prio_a[g] != '0);
    end

    assign any_qual = |qual;

    logic [N_IN-1:0]  taken;
    logic [PRI_W-1:0] best_p;
    logic             found;
    int unsigned      best_i;

    // Fill the rank slots in turn; each pass takes the best input not yet taken.
    always_comb begin
        taken  = '0;
        picks  = '0;
        best_p = '0;
        found  = 1'b0;
        best_i = 0;
        for (int k = 0; k < SLOTS; k++) begin
            best_p = '1;
            found  = 1'b0;
            best_i = 0;
            for (int i = 0; i < N_IN; i++) begin
                if (qual[i] && !taken[i] && (!found || prio_a[i] < best_p)) begin
                    found  = 1'b1;
                    best_p = prio_a[i];
                    best_i = i;
                end
            end
            if (found) begin
                picks[k*IDX_W +: IDX_W] = IDX_W'(to_index(best_i));
                taken[best_i]           = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ref_sel_ctrl.sv
// Module: ref_sel_ctrl
// Purpose: holds the selected reference and applies the switching policy.
// Assumes: best_idx is the one-based best qualified input (0 = none) for the
//          current inputs, and qual is the per-input qualification vector.
module ref_sel_ctrl #(
    parameter int N_IN  = 14,
    parameter int IDX_W = $clog2(N_IN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             revertive,
    input  logic [N_IN-1:0]  qual,
    input  logic [IDX_W-1:0] best_idx,
    output logic [IDX_W-1:0] sel_q
);
    import ref_sel_pkg::*;

    localparam int EXT_W = 1 << IDX_W;

    logic [EXT_W-1:0] qual_ext;
    logic             keep;
    sw_policy_e       policy;

    // Widen the qualification vector so that any index value can be looked up.
    always_comb begin
        qual_ext = EXT_W'({qual, 1'b0});
        policy   = sw_policy_e'(revertive);
        keep     = (policy == SW_HOLD) && (sel_q != '0) && qual_ext[sel_q];
    end

    // Register the selection: hold the current input or take the best one.
    always_ff @(posedge clk) begin
        if (!rst_n)    sel_q <= '0;
        else if (!keep) sel_q <= best_idx;
    end

    // R6: in hold mode, a still-qualified selection is never replaced.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!revertive && sel_q != '0 && qual_ext[sel_q]) |=> $stable(sel_q));

    // R7: in hold mode, a lost or empty selection moves to the best input.
    p_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!revertive && !(sel_q != '0 && qual_ext[sel_q])) |=> (sel_q == $past(best_idx)));
endmodule

// File: rtl/ref_loss_flag.sv
// Module: ref_loss_flag
// Purpose: sticky flag for the loss of every qualified input, with masked interrupt.
// Assumes: any_now is the combinational "some input qualified" signal; clr is
//          a write-one-to-clear pulse; a set beats a clear in the same cycle.
module ref_loss_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic any_now,
    input  logic clr,
    input  logic en,
    output logic sticky,
    output logic irq
);
    logic any_d;
    logic set_ev;

    // Detect the edge at which the last qualified input disappears.
    assign set_ev = any_d && !any_now;

    // Remember whether an input was qualified in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) any_d <= 1'b0;
        else        any_d <= any_now;
    end

    // Sticky flag: set on the loss event, otherwise cleared by the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      sticky <= 1'b0;
        else if (set_ev) sticky <= 1'b1;
        else if (clr)    sticky <= 1'b0;
    end

    // Interrupt output, gated by the enable.
    assign irq = sticky && en;

    // R9: the loss event always leaves the flag set.
    p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (any_d && !any_now) |=> sticky);

    // R9: without a clear, the flag never drops by itself.
    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !clr) |=> sticky);

    // R10: no interrupt while the enable is low.
    p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !irq);
endmodule

// File: rtl/ref_clk_selector.sv
// Module: ref_clk_selector (top)
// Purpose: ranks candidate references, registers the top three and the
//          selection, and flags the loss of all candidates.
// Assumes: qualification flags are synchronous to clk; every output except
//          irq is registered, so it follows the inputs by one edge.
module ref_clk_selector #(
    parameter  int N_IN  = 14,
    parameter  int PRI_W = 4,
    localparam int IDX_W = $clog2(N_IN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_IN-1:0]       in_valid,
    input  logic [N_IN*PRI_W-1:0] in_prio,
    input  logic                  revertive,
    input  logic                  irq_en,
    input  logic                  lost_clr,
    output logic [IDX_W-1:0]      sel_idx,
    output logic [IDX_W-1:0]      rank1,
    output logic [IDX_W-1:0]      rank2,
    output logic [IDX_W-1:0]      rank3,
    output logic                  all_lost,
    output logic                  irq
);
    import ref_sel_pkg::*;

    localparam int SLOTS = RANK_SLOTS;

    logic [N_IN-1:0]        qual;
    logic [SLOTS*IDX_W-1:0] picks;
    logic                   any_qual;
    logic [IDX_W-1:0]       rank_q [SLOTS];

    ref_rank_core #(
        .N_IN (N_IN),
        .PRI_W(PRI_W),
        .SLOTS(SLOTS),
        .IDX_W(IDX_W)
    ) u_rank (
        .valid   (in_valid),
        .prio    (in_prio),
        .qual    (qual),
        .picks   (picks),
        .any_qual(any_qual)
    );

    // Register each ranking slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_rank_reg
        always_ff @(posedge clk) begin
            if (!rst_n) rank_q[s] <= '0;
            else        rank_q[s] <= picks[s*IDX_W +: IDX_W];
        end
    end

    assign rank1 = rank_q[0];
    assign rank2 = rank_q[1];
    assign rank3 = rank_q[2];

    ref_sel_ctrl #(
        .N_IN (N_IN),
        .IDX_W(IDX_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .revertive(revertive),
        .qual     (qual),
        .best_idx (picks[IDX_W-1:0]),
        .sel_q    (sel_idx)
    );

    ref_loss_flag u_loss (
        .clk   (clk),
        .rst_n (rst_n),
        .any_now(any_qual),
        .clr   (lost_clr),
        .en    (irq_en),
        .sticky(all_lost),
        .irq   (irq)
    );

    // R5: in follow mode, the selection equals the best-ranked input.
    p_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        revertive |=> (sel_idx == rank1));

    // R8: with no ranked input, nothing is selected.
    p_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rank1 == '0) |-> (sel_idx == '0));

    // R3: slots fill from the top, and the first two are distinct.
    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rank2 != '0) |-> (rank1 != '0 && rank1 != rank2 && (rank3 == '0 || rank3 != rank2)));
endmodule

// File: tb/ref_clk_selector_bench.sv
// Bench: a table of input vectors with expected ranking and selection,
// followed by directed tests of reset, the loss flag, interrupt and latency.
module ref_clk_selector_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] in_valid;
    logic [55:0] in_prio;
    logic        revertive;
    logic        irq_en;
    logic        lost_clr;
    logic [3:0]  sel_idx, rank1, rank2, rank3;
    logic        all_lost, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ref_clk_selector u_ref_clk_selector (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_prio(in_prio),
        .revertive(revertive), .irq_en(irq_en), .lost_clr(lost_clr),
        .sel_idx(sel_idx), .rank1(rank1), .rank2(rank2), .rank3(rank3),
        .all_lost(all_lost), .irq(irq)
    );

    typedef struct packed {
        logic        rev;
        logic [13:0] valid;
        logic [55:0] prio;
        logic [3:0]  sel;
        logic [3:0]  r1;
        logic [3:0]  r2;
        logic [3:0]  r3;
    } vec_t;

    localparam int NV = 11;
    // Priority nibble i belongs to input i+1 (rightmost hex digit = input 1).
    localparam vec_t VECS [NV] = '{
        {1'b1, 14'h0000, 56'h11111111111111, 4'd0,  4'd0,  4'd0,  4'd0},  // R8 nothing valid
        {1'b1, 14'h0007, 56'h00000000000213, 4'd2,  4'd2,  4'd3,  4'd1},  // R2/R3 scrambled
        {1'b1, 14'h000F, 56'h00000000005555, 4'd1,  4'd1,  4'd2,  4'd3},  // R4 four-way tie
        {1'b1, 14'h0003, 56'h00000000000040, 4'd2,  4'd2,  4'd0,  4'd0},  // R2 prio 0 disables
        {1'b1, 14'h3000, 56'h22000000000000, 4'd13, 4'd13, 4'd14, 4'd0},  // R4 top indices
        {1'b0, 14'h0003, 56'h00000000000035, 4'd2,  4'd2,  4'd1,  4'd0},  // R7 sel lost
        {1'b0, 14'h0007, 56'h00000000000135, 4'd2,  4'd3,  4'd2,  4'd1},  // R6 better appears
        {1'b0, 14'h0007, 56'h00000000000105, 4'd3,  4'd3,  4'd1,  4'd0},  // R7 sel disabled
        {1'b1, 14'h0007, 56'h00000000000101, 4'd1,  4'd1,  4'd3,  4'd0},  // R5 follow tie winner
        {1'b0, 14'h0007, 56'h00000000000102, 4'd1,  4'd3,  4'd1,  4'd0},  // R6 hold
        {1'b0, 14'h0000, 56'h00000000000102, 4'd0,  4'd0,  4'd0,  4'd0}   // R8 all lost
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 14'h3FFF;
        in_prio   = '1;
        revertive = 1'b1;
        irq_en    = 1'b1;
        lost_clr  = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1 sel",   {4'd0, sel_idx}, 8'd0);
        chk("R1 rank1", {4'd0, rank1},   8'd0);
        chk("R1 lost",  {7'd0, all_lost}, 8'd0);
        in_valid = '0;
        rst_n    = 1'b1;
        @(negedge clk);

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            revertive = VECS[v].rev;
            in_valid  = VECS[v].valid;
            in_prio   = VECS[v].prio;
            @(negedge clk);
            chk($sformatf("R3 rank1 v%0d", v), {4'd0, rank1}, {4'd0, VECS[v].r1});
            chk($sformatf("R3 rank2 v%0d", v), {4'd0, rank2}, {4'd0, VECS[v].r2});
            chk($sformatf("R4 rank3 v%0d", v), {4'd0, rank3}, {4'd0, VECS[v].r3});
            chk($sformatf("R5/R6/R7/R8 sel v%0d", v), {4'd0, sel_idx}, {4'd0, VECS[v].sel});
        end

        // R9: last vector removed every qualified input, so the flag is set.
        chk("R9 set on loss", {7'd0, all_lost}, 8'd1);
        // R10: interrupt gating.
        irq_en = 1'b0;
        #1 chk("R10 masked", {7'd0, irq}, 8'd0);
        irq_en = 1'b1;
        #1 chk("R10 enabled", {7'd0, irq}, 8'd1);
        @(negedge clk);
        // R9: clear pulse while the input set stays empty; no new set afterwards.
        lost_clr = 1'b1;
        @(negedge clk);
        lost_clr = 1'b0;
        chk("R9 cleared", {7'd0, all_lost}, 8'd0);
        @(negedge clk);
        chk("R9 no reset while empty", {7'd0, all_lost}, 8'd0);

        // R11: latency of one edge.
        revertive = 1'b0;
        in_valid  = 14'h0010;
        in_prio   = 56'h00000000010000;
        #1 chk("R11 before edge", {4'd0, sel_idx}, 8'd0);
        @(negedge clk);
        chk("R11 after edge", {4'd0, sel_idx}, 8'd5);
        chk("R7 empty to best", {4'd0, rank1}, 8'd5);

        // R9: set beats a simultaneous clear.
        in_valid = '0;
        lost_clr = 1'b1;
        @(negedge clk);
        lost_clr = 1'b0;
        chk("R9 set wins", {7'd0, all_lost}, 8'd1);
        chk("R8 sel none", {4'd0, sel_idx}, 8'd0);

        // R1: synchronous reset mid-run.
        in_valid = 14'h0001;
        in_prio  = 56'h1;
        rst_n    = 1'b0;
        @(negedge clk);
        chk("R1 mid reset lost", {7'd0, all_lost}, 8'd0);
        chk("R1 mid reset sel",  {4'd0, sel_idx},  8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after reset", {4'd0, sel_idx}, 8'd1);

        done = 1'b1;
        finish_run();
    end
endmodule